// File: doc/BRIEF.md
# Floppy Drive Control Registers

This block is the host-facing register set of a floppy disk controller. A byte-wide register bus with a 3-bit offset reaches a drive control register, a write-only rate/power register, a rate-only control register, a small tape register and a read-only input status register. The register contents drive the physical drive-select lines, the four motor enables, the 2-bit data rate code, the write precompensation amount, a DMA/interrupt gate, and a power-down flag.

The block merges three reset sources into one controller reset: the asynchronous pin reset, a hold bit in the drive control register, and a self-timed software reset pulse started from the rate/power register. Any of these takes the controller out of power-down. An interface-mode input selects between AT behaviour and PS/2 behaviour. The mode changes which bits the input status register drives and whether the DMA enable bit is used.

Reads are combinational while `sel_i` is high and `wr_i` is low. `rdata_oe_o` marks the bits that are actually driven. Undriven bits read as 0 on `rdata_o`. Writes take effect on the clock edge where `sel_i` and `wr_i` are both high.

Top module: `fdc_ctl_regs`

## Requirements

- R1: After the pin reset the outputs are:
  - drive 0 is selected (`drv_sel_o` = 0001);
  - all motors are off;
  - `rate_o` holds the reset code (default 00) and precompensation is 0;
  - power-down is clear;
  - the DMA gate is off in AT mode;
  - the tape bits are 0.
- R2: A write to offset 2 sets the drive control register:
  - bits 1:0 pick the drive, and `drv_sel_o` shows it one-hot with bit n for drive n;
  - bits 7:4 drive `motor_o[3:0]` for drives 0 to 3;
  - a read of offset 2 returns the whole byte with all bits driven.
- R3: The 2-bit rate code is shared by two registers:
  - bits 1:0 of a write to offset 4 or to offset 7 update `rate_o`, and the last write wins;
  - the encoding is 00 = 500 kbps, 01 = 300 kbps, 10 = 250 kbps, 11 = 1 Mbps.
- R4: A write to offset 4 loads bits 4:2 into `precomp_o`. Bit 6 of the same write requests power-down, which shows on `pwr_down_o` after the write.
- R5: `ctrl_rst_o` is high whenever any of these holds:
  - the pin reset is low;
  - bit 2 of the drive control register is 1;
  - the software reset pulse is running.
- R6: A write to offset 4 with bit 7 set starts the software reset pulse on the next cycle. The pulse lasts exactly SRST_CYC cycles and then clears by itself.
- R7: Any controller reset clears power-down. A power-down request made while a reset is active, or in the same write as a software reset, is not taken.
- R8: The tape register at offset 3 stores only bits 1:0. A read drives only bits 1:0 (`rdata_oe_o` = 03h) and leaves bits 7:2 undriven.
- R9: A read of offset 7 reports `disk_chg_i` on bit 7, with two layouts:
  - in AT mode (`ps2_mode_i` = 0) only bit 7 is driven (`rdata_oe_o` = 80h);
  - in PS/2 mode all bits are driven, bits 6:2 read as 1 and bits 1:0 return the rate code.
- R10: The DMA enable (bit 3 of the drive control register) gates `dma_gate_o` in AT mode. In PS/2 mode the bit is ignored and `dma_gate_o` is 1.
- R11: Offsets 0, 1, 5 and 6, and reads of the write-only offset 4, drive no data bits. Writes to offsets 0, 1, 5 and 6 change no output.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous pin reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (undriven bits are 0) |
| rdata_oe_o | output | 8 | Per-bit drive enable of read data |
| ps2_mode_i | input | 1 | Interface mode: 0 = AT, 1 = PS/2 |
| disk_chg_i | input | 1 | Disk-change input from the drive |
| drv_sel_o | output | 4 | One-hot drive select |
| motor_o | output | 4 | Motor enables, drives 0 to 3 |
| rate_o | output | 2 | Data rate code |
| precomp_o | output | 3 | Write precompensation amount |
| pwr_down_o | output | 1 | Power-down flag |
| ctrl_rst_o | output | 1 | Merged controller reset |
| dma_gate_o | output | 1 | DMA request / interrupt gate |

## Verification

The bench builds the block with SRST_CYC = 5 instead of the default. A pulse length that differs from the default makes an off-by-one in the self-timed reset show up as a wrong pulse count, not as a coincidence. The rate reset code stays at 00, so the reset check compares against the 500 kbps code.

Random writes to every offset, with the interface mode flipped at random, bring these interactions within reach:
- the hold bit set while power-down is requested;
- the rate code written alternately through both rate registers;
- status reads in both modes.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;
  localparam logic [2:0] OFS_DOR   = 3'd2;
  localparam logic [2:0] OFS_TAPE  = 3'd3;
  localparam logic [2:0] OFS_RATE  = 3'd4;
  localparam logic [2:0] OFS_INCCR = 3'd7;

  typedef struct packed {
    logic [3:0] motor;
    logic       dma_en;
    logic       hold_rst;
    logic [1:0] sel;
  } dor_t;
endpackage

// File: rtl/fdc_dor_reg.sv
module fdc_dor_reg
  import fdc_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output dor_t       dor_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dor_o <= '0;
    else if (we_i) dor_o <= dor_t'(wdata_i);
  end
endmodule

// File: rtl/fdc_rate_ctl.sv
module fdc_rate_ctl #(
  parameter int unsigned SRST_CYC = 4,
  parameter logic [1:0]  RATE_RST = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dsr_we_i,
  input  logic       ccr_we_i,
  input  logic [7:0] wdata_i,
  input  logic       hold_rst_i,
  output logic [1:0] rate_o,
  output logic [2:0] precomp_o,
  output logic       pwr_down_o,
  output logic       sw_rst_o
);
  localparam int unsigned CNT_W = $clog2(SRST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             soft_req;
  logic             any_rst;

  assign soft_req = dsr_we_i && wdata_i[7];
  assign sw_rst_o = (cnt_q != '0);
  assign any_rst  = hold_rst_i || sw_rst_o || soft_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_o     <= RATE_RST;
      precomp_o  <= '0;
      pwr_down_o <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (dsr_we_i) begin
        rate_o    <= wdata_i[1:0];
        precomp_o <= wdata_i[4:2];
      end else if (ccr_we_i) begin
        rate_o    <= wdata_i[1:0];
      end
      if (soft_req)       cnt_q <= CNT_W'(SRST_CYC);
      else if (sw_rst_o)  cnt_q <= cnt_q - 1'b1;
      // any reset source wins over a power-down request
      if (any_rst)                    pwr_down_o <= 1'b0;
      else if (dsr_we_i && wdata_i[6]) pwr_down_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fdc_rd_mux.sv
module fdc_rd_mux
  import fdc_regs_pkg::*;
(
  input  logic       re_i,
  input  logic [2:0] addr_i,
  input  dor_t       dor_i,
  input  logic [1:0] tape_i,
  input  logic [1:0] rate_i,
  input  logic       ps2_mode_i,
  input  logic       disk_chg_i,
  output logic [7:0] rdata_o,
  output logic [7:0] oe_o
);
  always_comb begin
    rdata_o = '0;
    oe_o    = '0;
    if (re_i) begin
      unique case (addr_i)
        OFS_DOR: begin
          rdata_o = dor_i;
          oe_o    = 8'hff;
        end
        OFS_TAPE: begin
          rdata_o = {6'b0, tape_i};
          oe_o    = 8'h03;
        end
        OFS_INCCR: begin
          if (ps2_mode_i) begin
            rdata_o = {disk_chg_i, 5'b11111, rate_i};
            oe_o    = 8'hff;
          end else begin
            rdata_o = {disk_chg_i, 7'b0};
            oe_o    = 8'h80;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fdc_ctl_regs.sv
module fdc_ctl_regs
  import fdc_regs_pkg::*;
#(
  parameter int unsigned SRST_CYC = 4,
  parameter logic [1:0]  RATE_RST = 2'b00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic [7:0] rdata_oe_o,
  input  logic       ps2_mode_i,
  input  logic       disk_chg_i,
  output logic [3:0] drv_sel_o,
  output logic [3:0] motor_o,
  output logic [1:0] rate_o,
  output logic [2:0] precomp_o,
  output logic       pwr_down_o,
  output logic       ctrl_rst_o,
  output logic       dma_gate_o
);
  localparam int unsigned NUM_DRV = 4;

  logic       we, re;
  dor_t       dor_q;
  logic [1:0] tape_q;
  logic       sw_rst;

  assign we = sel_i && wr_i;
  assign re = sel_i && !wr_i;

  fdc_dor_reg u_dor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we && addr_i == OFS_DOR),
    .wdata_i (wdata_i),
    .dor_o   (dor_q)
  );

  fdc_rate_ctl #(.SRST_CYC(SRST_CYC), .RATE_RST(RATE_RST)) u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dsr_we_i   (we && addr_i == OFS_RATE),
    .ccr_we_i   (we && addr_i == OFS_INCCR),
    .wdata_i    (wdata_i),
    .hold_rst_i (dor_q.hold_rst),
    .rate_o     (rate_o),
    .precomp_o  (precomp_o),
    .pwr_down_o (pwr_down_o),
    .sw_rst_o   (sw_rst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       tape_q <= '0;
    else if (we && addr_i == OFS_TAPE) tape_q <= wdata_i[1:0];
  end

  fdc_rd_mux u_rd (
    .re_i       (re),
    .addr_i     (addr_i),
    .dor_i      (dor_q),
    .tape_i     (tape_q),
    .rate_i     (rate_o),
    .ps2_mode_i (ps2_mode_i),
    .disk_chg_i (disk_chg_i),
    .rdata_o    (rdata_o),
    .oe_o       (rdata_oe_o)
  );

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
    assign drv_sel_o[i] = (dor_q.sel == 2'(i));
  end

  assign motor_o    = dor_q.motor;
  assign ctrl_rst_o = !rst_ni || dor_q.hold_rst || sw_rst;
  assign dma_gate_o = ps2_mode_i || dor_q.dma_en;
endmodule

// File: rtl/fdc_ctl_regs_chk.sv
module fdc_ctl_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_oe_o,
  input logic [3:0] motor_o,
  input logic [1:0] rate_o,
  input logic       pwr_down_o,
  input logic       ctrl_rst_o,
  input logic       hold_rst_i
);
  p_motor_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i && addr_i == 3'd2) |=> $stable(motor_o));

  p_rate_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i && (addr_i == 3'd4 || addr_i == 3'd7)) |=> $stable(rate_o));

  p_dor_rst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst_i |-> ctrl_rst_o);

  p_soft_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == 3'd4 && wdata_i[7]) |=> ctrl_rst_o);

  p_pwr_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_o |=> !pwr_down_o);

  p_wo_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i == 3'd4) |-> rdata_oe_o == 8'h00);
endmodule

bind fdc_ctl_regs fdc_ctl_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_oe_o (rdata_oe_o),
  .motor_o    (motor_o),
  .rate_o     (rate_o),
  .pwr_down_o (pwr_down_o),
  .ctrl_rst_o (ctrl_rst_o),
  .hold_rst_i (dor_q.hold_rst)
);

// File: tb/fdc_ctl_regs_tb_top.sv
module fdc_ctl_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SRST = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata_oe;
  logic       ps2 = 1'b0, chg = 1'b0;
  logic [3:0] drv_sel, motor;
  logic [1:0] rate;
  logic [2:0] precomp;
  logic       pwr_down, ctrl_rst, dma_gate;

  int n_chk = 0, n_bad = 0;

  logic [7:0] m_dor = '0;
  logic [1:0] m_tape = '0, m_rate = '0;
  logic [2:0] m_pre = '0;
  logic       m_pwr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_ctl_regs #(.SRST_CYC(SRST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .ps2_mode_i(ps2), .disk_chg_i(chg), .drv_sel_o(drv_sel), .motor_o(motor),
    .rate_o(rate), .precomp_o(precomp), .pwr_down_o(pwr_down),
    .ctrl_rst_o(ctrl_rst), .dma_gate_o(dma_gate)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd2: exp_rd = {8'hff, m_dor};
      3'd3: exp_rd = {8'h03, 6'b0, m_tape};
      3'd7: exp_rd = ps2 ? {8'hff, chg, 5'b11111, m_rate} : {8'h80, chg, 7'b0};
      default: exp_rd = 16'h0000;
    endcase
  endfunction

  task automatic check_outs(input string tag);
    chk({tag, " R2 drv_sel"}, drv_sel, 4'b0001 << m_dor[1:0]);
    chk({tag, " R2 motor"},   motor, m_dor[7:4]);
    chk({tag, " R3 rate"},    rate, m_rate);
    chk({tag, " R4 precomp"}, precomp, m_pre);
    chk({tag, " R7 pwr_down"}, pwr_down, m_pwr);
    chk({tag, " R5 ctrl_rst"}, ctrl_rst, m_dor[2]);
    chk({tag, " R10 dma_gate"}, dma_gate, ps2 | m_dor[3]);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    case (a)
      3'd2: begin m_dor = d; if (d[2]) m_pwr = 1'b0; end
      3'd3: m_tape = d[1:0];
      3'd4: begin
        m_rate = d[1:0]; m_pre = d[4:2];
        if (m_dor[2] || d[7]) m_pwr = 1'b0;
        else if (d[6]) m_pwr = 1'b1;
      end
      3'd7: m_rate = d[1:0];
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    logic [15:0] e;
    e = exp_rd(a);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    chk({tag, " oe"},   rdata_oe, e[15:8]);
    chk({tag, " data"}, rdata & e[15:8], e[7:0]);
    sel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R5 pin reset drives ctrl_rst", ctrl_rst, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 reset");
    rd_chk(3'd3, "R1 R8 tape after reset");

    // R2 drive select and motors
    wr_reg(3'd2, 8'hf3);
    check_outs("R2 dor f3");
    rd_chk(3'd2, "R2 dor readback");
    wr_reg(3'd2, 8'h51);
    check_outs("R2 dor 51");

    // R3/R4 rate, precomp, power-down
    wr_reg(3'd4, 8'h57);
    check_outs("R4 dsr 57");
    chk("R4 pwr set", pwr_down, 1);
    wr_reg(3'd7, 8'h02);
    check_outs("R3 ccr last wins");
    rd_chk(3'd4, "R11 dsr write-only");

    // R5/R7 hold reset clears power-down and blocks requests
    wr_reg(3'd2, 8'h04);
    check_outs("R5 R7 dor hold");
    chk("R7 pwr cleared", pwr_down, 0);
    wr_reg(3'd4, 8'h40);
    check_outs("R7 pwr blocked in hold");
    wr_reg(3'd2, 8'h00);
    check_outs("R5 hold released");

    // R6 soft reset pulse
    wr_reg(3'd4, 8'h40);
    chk("R4 pwr before soft", pwr_down, 1);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 3'd4; wdata = 8'hc1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    begin
      int n;
      n = 0;
      while (ctrl_rst && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk("R6 pulse length", n, SRST);
    end
    m_rate = 2'b01; m_pre = 3'b000; m_pwr = 1'b0;
    check_outs("R6 R7 after soft");

    // R8 tape
    wr_reg(3'd3, 8'hff);
    rd_chk(3'd3, "R8 tape ff");

    // R9 input status, R10 DMA gate
    chg = 1'b1;
    rd_chk(3'd7, "R9 at mode");
    ps2 = 1'b1;
    rd_chk(3'd7, "R9 ps2 mode");
    check_outs("R10 ps2 forces gate");
    ps2 = 1'b0;
    #1 check_outs("R10 at gate off");
    wr_reg(3'd2, 8'h08);
    check_outs("R10 at gate on");

    // R11 undecoded offsets
    for (int i = 0; i < 4; i++) begin
      logic [2:0] a;
      a = (i < 2) ? 3'(i) : 3'(i + 3);
      wr_reg(a, 8'($urandom));
      check_outs("R11 undecoded write");
      rd_chk(a, "R11 undecoded read");
    end

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom);
      d = 8'($urandom);
      if (a == 3'd4) d[7] = 1'b0;
      ps2 = 1'($urandom);
      chg = 1'($urandom);
      wr_reg(a, d);
      check_outs("R2 R3 R4 R7 random");
      rd_chk(3'($urandom), "R8 R9 R11 random read");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule